// File: doc/BRIEF.md
# Frame-Aligned Transparent Serial Transmitter

This block moves bytes from a transmit FIFO onto a time-division serial line without altering them. The line repeats a frame with up to three byte-wide channels: two bearer slots and one signalling slot. A channel-select mask chooses which of these carry message data. No flags are added, no zero bits are inserted and no check sequence is appended. Every bit of every FIFO byte reaches the line as it is, most significant bit first.

The host first loads the FIFO. It then pulses a send command and, when the FIFO holds the whole message, a last-byte command. Output begins at the first selected slot of the frame that follows the command. When the message has drained, the block pulses a completion interrupt and returns to idle, sending ones. If the FIFO runs dry before message end has been given, the block aborts with an underrun interrupt. When collision detection is enabled, a stop/go input acts as clear-to-send. A stop seen during a message aborts it with a retry interrupt. The frame timing comes from outside as a frame-start strobe, a bit-slot enable and a slot index.

Top module: `tdm_xparent_tx`

## Requirements
- R1: In each bit slot whose channel is selected, the line carries the FIFO bytes unchanged, most significant bit first. Selection uses `chan_sel` bit k for `slot_id` k (0 and 1 are the bearer channels, 2 is the signalling channel). One byte is popped from the FIFO at the start of each byte.
- R2: After `cmd_send`, the rest of the current frame carries ones. Data starts in the first selected slot of the next frame, which begins with the `frame_sync` strobe on its first bit slot.
- R3: Bit slots that are not selected, any `slot_id` of 3 or more, and all slots while no message is active carry logic 1.
- R4: With message end given (`cmd_last`), `irq_done` rises in the cycle in which the last bit of the last byte appears on `tx_data`. If the FIFO was empty at the start, it rises in the first selected slot instead. The block then idles.
- R5: With `coll_det_en` = 1, `stop_go` = 1 during an active message raises `irq_retry`. The message is dropped, and ones follow in every later slot.
- R6: With `coll_det_en` = 0, `stop_go` has no effect on the data or on the interrupts.
- R7: If a byte must start in a selected slot while the FIFO is empty and message end has not been given, `irq_underrun` rises in that slot. The line then carries ones and the block idles.
- R8: Each interrupt output is high for exactly one clock cycle, and at most one of the three is high at any time.
- R9: A `cmd_send` that arrives while a message is in progress is ignored.
- R10: After reset, `tx_data` is 1 and `fifo_rd` and all interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | High on the first bit slot of each frame |
| bit_en | input | 1 | One bit slot of the serial line in this cycle |
| slot_id | input | SLOT_W | Channel that the current bit slot belongs to |
| chan_sel | input | NUM_SLOTS | Mask of channels that carry message data |
| cmd_send | input | 1 | Host pulse: start a message |
| cmd_last | input | 1 | Host pulse: FIFO holds the end of the message |
| coll_det_en | input | 1 | Enables stop/go as clear-to-send |
| stop_go | input | 1 | 1 = stop, 0 = go |
| fifo_empty | input | 1 | Transmit FIFO has no byte |
| fifo_rdata | input | DATA_W | Head byte of the FIFO (show-ahead) |
| fifo_rd | output | 1 | Pops the head byte this cycle |
| tx_data | output | 1 | Registered serial data |
| irq_done | output | 1 | Message-complete pulse |
| irq_retry | output | 1 | Message-repeat pulse after a stop |
| irq_underrun | output | 1 | FIFO underrun pulse |

## Verification
The bench builds the block with its defaults: 8-bit bytes, three channels and a 2-bit slot index. This makes each frame 24 bit slots long, with a bit slot every second clock so that the output must hold between slots. With these sizes, single-channel, two-channel and all-channel masks can be run over four frames. That covers messages that span frame boundaries, an empty message, stops in selected and unselected slots, and underruns found one frame after the last byte.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_ACTIVE = 2'd2
  } tx_state_t;
endpackage

// File: rtl/tdm_slot_gate.sv
module tdm_slot_gate #(
  parameter int NUM_SLOTS = 3,
  parameter int SLOT_W    = 2
) (
  input  logic                 bit_en,
  input  logic [SLOT_W-1:0]    slot_id,
  input  logic [NUM_SLOTS-1:0] chan_sel,
  output logic                 slot_hit
);
  logic [NUM_SLOTS-1:0] match;

  genvar g;
  generate
    for (g = 0; g < NUM_SLOTS; g++) begin : g_slot
      assign match[g] = chan_sel[g] && (slot_id == SLOT_W'(g));
    end
  endgenerate

  assign slot_hit = bit_en && (|match);
endmodule

// File: rtl/tdm_byte_shifter.sv
module tdm_byte_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift,
  input  logic              flush,
  output logic              sh_msb,
  output logic              sh_empty,
  output logic              sh_last
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      sh_q  <= '1;
      cnt_q <= '0;
    end else if (load) begin
      sh_q  <= {load_data[DATA_W-2:0], 1'b1};
      cnt_q <= CNT_W'(DATA_W - 1);
    end else if (shift) begin
      sh_q  <= {sh_q[DATA_W-2:0], 1'b1};
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign sh_msb   = sh_q[DATA_W-1];
  assign sh_empty = (cnt_q == '0);
  assign sh_last  = (cnt_q == CNT_W'(1));

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(DATA_W - 1));
endmodule

// File: rtl/tdm_tx_ctrl.sv
module tdm_tx_ctrl
  import tdm_tx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic slot_hit,
  input  logic frame_sync,
  input  logic cmd_send,
  input  logic cmd_last,
  input  logic coll_det_en,
  input  logic stop_go,
  input  logic fifo_empty,
  input  logic fifo_msb,
  input  logic sh_msb,
  input  logic sh_empty,
  input  logic sh_last,
  output logic pop,
  output logic shift,
  output logic flush,
  output logic tx_data,
  output logic irq_done,
  output logic irq_retry,
  output logic irq_underrun
);
  tx_state_t st_q, st_d;
  logic last_q, last_d;
  logic live, abort, need, last_eff, fin_done, fin_under, stop_all;

  always_comb begin
    live      = (st_q == ST_ACTIVE) || ((st_q == ST_ARMED) && frame_sync);
    abort     = live && coll_det_en && stop_go;
    need      = live && slot_hit && sh_empty && !abort;
    shift     = live && slot_hit && !sh_empty && !abort;
    pop       = need && !fifo_empty;
    last_eff  = last_q || cmd_last;
    fin_done  = last_eff && fifo_empty && ((shift && sh_last) || need);
    fin_under = need && fifo_empty && !last_eff;
    stop_all  = abort || fin_done || fin_under;
    flush     = stop_all;
  end

  always_comb begin
    st_d   = st_q;
    last_d = last_q;
    unique case (st_q)
      ST_IDLE: begin
        if (cmd_send) begin
          st_d   = ST_ARMED;
          last_d = cmd_last;
        end
      end
      ST_ARMED: begin
        last_d = last_eff;
        if (frame_sync) st_d = stop_all ? ST_IDLE : ST_ACTIVE;
      end
      ST_ACTIVE: begin
        last_d = last_eff;
        if (stop_all) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    if (st_d == ST_IDLE && st_q != ST_IDLE) last_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_IDLE;
      last_q       <= 1'b0;
      tx_data      <= 1'b1;
      irq_done     <= 1'b0;
      irq_retry    <= 1'b0;
      irq_underrun <= 1'b0;
    end else begin
      st_q         <= st_d;
      last_q       <= last_d;
      irq_done     <= fin_done;
      irq_retry    <= abort;
      irq_underrun <= fin_under;
      if (pop)                      tx_data <= fifo_msb;
      else if (shift)               tx_data <= sh_msb;
      else if (bit_en || stop_all)  tx_data <= 1'b1;
    end
  end

  // R3
  idle_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && bit_en) |=> tx_data);

  // R8
  irq_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irq_done, irq_retry, irq_underrun}));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq_done |=> !irq_done);

  // R6
  no_retry_chk: assert property (@(posedge clk) disable iff (rst)
    !coll_det_en |=> !irq_retry);

  // R5
  retry_on_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ACTIVE && coll_det_en && stop_go) |=> (irq_retry && st_q == ST_IDLE));

  // R2
  no_pop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_ACTIVE && !frame_sync) |-> !pop);
endmodule

// File: rtl/tdm_xparent_tx.sv
module tdm_xparent_tx #(
  parameter int DATA_W    = 8,
  parameter int NUM_SLOTS = 3,
  parameter int SLOT_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_sync,
  input  logic                 bit_en,
  input  logic [SLOT_W-1:0]    slot_id,
  input  logic [NUM_SLOTS-1:0] chan_sel,
  input  logic                 cmd_send,
  input  logic                 cmd_last,
  input  logic                 coll_det_en,
  input  logic                 stop_go,
  input  logic                 fifo_empty,
  input  logic [DATA_W-1:0]    fifo_rdata,
  output logic                 fifo_rd,
  output logic                 tx_data,
  output logic                 irq_done,
  output logic                 irq_retry,
  output logic                 irq_underrun
);
  logic slot_hit, shift, flush, sh_msb, sh_empty, sh_last;

  tdm_slot_gate #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_gate (
    .bit_en   (bit_en),
    .slot_id  (slot_id),
    .chan_sel (chan_sel),
    .slot_hit (slot_hit)
  );

  tdm_byte_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (fifo_rd),
    .load_data (fifo_rdata),
    .shift     (shift),
    .flush     (flush),
    .sh_msb    (sh_msb),
    .sh_empty  (sh_empty),
    .sh_last   (sh_last)
  );

  tdm_tx_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .bit_en       (bit_en),
    .slot_hit     (slot_hit),
    .frame_sync   (frame_sync),
    .cmd_send     (cmd_send),
    .cmd_last     (cmd_last),
    .coll_det_en  (coll_det_en),
    .stop_go      (stop_go),
    .fifo_empty   (fifo_empty),
    .fifo_msb     (fifo_rdata[DATA_W-1]),
    .sh_msb       (sh_msb),
    .sh_empty     (sh_empty),
    .sh_last      (sh_last),
    .pop          (fifo_rd),
    .shift        (shift),
    .flush        (flush),
    .tx_data      (tx_data),
    .irq_done     (irq_done),
    .irq_retry    (irq_retry),
    .irq_underrun (irq_underrun)
  );

  // R1
  rd_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |-> (bit_en && !fifo_empty));
endmodule

// File: tb/tdm_xparent_tx_bench.sv
module tdm_xparent_tx_bench;
  localparam int DATA_W = 8;
  localparam int NUM_SLOTS = 3;
  localparam int SLOT_W = 2;
  localparam int FRAME_BITS = NUM_SLOTS * DATA_W;

  typedef struct packed {
    logic [2:0] sel;
    logic [3:0] nb;
    logic       last;
    logic       cd;
    logic [7:0] stop_at;
    logic       extra;
    logic [1:0] kind;   // 1 done, 2 retry, 3 underrun
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [0:NV-1] = '{
    '{3'b001, 4'd3, 1'b1, 1'b0, 8'd0,  1'b0, 2'd1},
    '{3'b111, 4'd5, 1'b1, 1'b0, 8'd0,  1'b0, 2'd1},
    '{3'b110, 4'd2, 1'b0, 1'b0, 8'd0,  1'b1, 2'd3},
    '{3'b100, 4'd0, 1'b1, 1'b0, 8'd0,  1'b0, 2'd1},
    '{3'b011, 4'd4, 1'b1, 1'b1, 8'd12, 1'b0, 2'd2},
    '{3'b011, 4'd4, 1'b1, 1'b0, 8'd12, 1'b0, 2'd1},
    '{3'b101, 4'd0, 1'b0, 1'b0, 8'd0,  1'b0, 2'd3},
    '{3'b010, 4'd1, 1'b0, 1'b1, 8'd20, 1'b0, 2'd2}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_sync = 1'b0, bit_en = 1'b0;
  logic [SLOT_W-1:0] slot_id = '0;
  logic [NUM_SLOTS-1:0] chan_sel = '0;
  logic cmd_send = 1'b0, cmd_last = 1'b0, coll_det_en = 1'b0, stop_go = 1'b0;
  logic fifo_empty, fifo_rd, tx_data, irq_done, irq_retry, irq_underrun;
  logic [DATA_W-1:0] fifo_rdata;

  logic [7:0] fq [0:15];
  logic [3:0] rp = '0;
  logic [3:0] wp = '0;
  logic fifo_clr = 1'b0;
  int checks = 0;
  int errors = 0;
  int hi_done = 0, hi_retry = 0, hi_under = 0;

  always #5 clk = ~clk;

  assign fifo_empty = (rp == wp);
  assign fifo_rdata = fq[rp];

  always @(posedge clk) begin
    if (fifo_clr) rp <= '0;
    else if (fifo_rd) rp <= rp + 1'b1;
    if (irq_done) hi_done <= hi_done + 1;
    if (irq_retry) hi_retry <= hi_retry + 1;
    if (irq_underrun) hi_under <= hi_under + 1;
  end

  tdm_xparent_tx #(.DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_tdm_xparent_tx (
    .clk(clk), .rst(rst), .frame_sync(frame_sync), .bit_en(bit_en), .slot_id(slot_id),
    .chan_sel(chan_sel), .cmd_send(cmd_send), .cmd_last(cmd_last),
    .coll_det_en(coll_det_en), .stop_go(stop_go), .fifo_empty(fifo_empty),
    .fifo_rdata(fifo_rdata), .fifo_rd(fifo_rd), .tx_data(tx_data),
    .irq_done(irq_done), .irq_retry(irq_retry), .irq_underrun(irq_underrun)
  );

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0h exp %0h (t=%0t)", tag, got, exp, $time);
    end
  endtask

  function automatic logic [7:0] byte_val(input int vi, input int i);
    return 8'hC3 ^ (8'(i) * 8'h2B) ^ 8'(vi * 7);
  endfunction

  task automatic run_vec(input int vi);
    vec_t v = VECS[vi];
    int bi = 0;
    bit running = 1'b0;
    int got_kind = 0;
    int d0, r0, u0;
    string tag;
    fifo_clr = 1'b1;
    @(posedge clk); #1;
    fifo_clr = 1'b0;
    wp = '0;
    for (int i = 0; i < int'(v.nb); i++) begin
      fq[wp] = byte_val(vi, i);
      wp = wp + 1'b1;
    end
    chan_sel = v.sel;
    coll_det_en = v.cd;
    d0 = hi_done; r0 = hi_retry; u0 = hi_under;
    for (int f = 0; f < 5; f++) begin
      if (f == 1) running = 1'b1;
      for (int b = 0; b < FRAME_BITS; b++) begin
        int s = b / DATA_W;
        bit e = 1'b1, xp = 1'b0, xm = 1'b0, xu = 1'b0;
        tag = (f == 0) ? "R2" : "R3";
        bit_en = 1'b1;
        frame_sync = (b == 0);
        slot_id = SLOT_W'(s);
        cmd_send = (f == 0 && b == 5) || (v.extra && f == 1 && b == 3);
        cmd_last = (f == 0 && b == 5) ? v.last : 1'b0;
        stop_go = (f == 1 && v.stop_at != 0 && b == int'(v.stop_at));
        if (running) begin
          if (v.cd && stop_go) begin
            running = 1'b0; xm = 1'b1; tag = "R5";
          end else if (v.sel[s]) begin
            if (bi < int'(v.nb) * 8) begin
              logic [7:0] by = byte_val(vi, bi / 8);
              e = by[7 - (bi % 8)];
              tag = v.extra ? "R9" : (stop_go ? "R6" : "R1");
              bi++;
              if (bi == int'(v.nb) * 8 && v.last) begin
                xp = 1'b1; running = 1'b0;
              end
            end else begin
              if (v.last) xp = 1'b1; else xu = 1'b1;
              running = 1'b0;
            end
          end
        end
        @(posedge clk); #1;
        chk(tx_data == e, tag, tx_data, e);
        chk(irq_done == xp, "R4", irq_done, xp);
        chk(irq_retry == xm, v.cd ? "R5" : "R6", irq_retry, xm);
        chk(irq_underrun == xu, "R7", irq_underrun, xu);
        if (irq_done) got_kind = 1;
        if (irq_retry) got_kind = 2;
        if (irq_underrun) got_kind = 3;
        bit_en = 1'b0; frame_sync = 1'b0; cmd_send = 1'b0; cmd_last = 1'b0; stop_go = 1'b0;
        @(posedge clk); #1;
        chk(tx_data == e, "R3", tx_data, e);
      end
    end
    chk(got_kind == int'(v.kind), v.kind == 2'd1 ? "R4" : (v.kind == 2'd2 ? "R5" : "R7"),
        got_kind, v.kind);
    chk((hi_done - d0) + (hi_retry - r0) + (hi_under - u0) == 1, "R8",
        (hi_done - d0) + (hi_retry - r0) + (hi_under - u0), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(tx_data == 1'b1, "R10", tx_data, 1);
    chk({irq_done, irq_retry, irq_underrun} == 3'b000, "R10",
        {irq_done, irq_retry, irq_underrun}, 0);
    rst = 1'b0;
    #1;
    chk(fifo_rd == 1'b0, "R10", fifo_rd, 0);
    for (int vi = 0; vi < NV; vi++) run_vec(vi);
    // R3: slot_id beyond the channel range never carries data
    chan_sel = '1;
    fifo_clr = 1'b1; @(posedge clk); #1; fifo_clr = 1'b0;
    fq[0] = 8'h00; wp = 4'd1;
    slot_id = 2'd3; bit_en = 1'b1; frame_sync = 1'b1; cmd_send = 1'b0;
    @(posedge clk); #1;
    chk(tx_data == 1'b1, "R3", tx_data, 1);
    chk(fifo_rd == 1'b0, "R3", fifo_rd, 0);
    bit_en = 1'b0; frame_sync = 1'b0;
    @(posedge clk); #1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog got 0 exp 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule